// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block is a small, fully associative translation buffer whose entries are loaded and examined by software through a set of staging registers. Each entry holds a virtual page-pair number, a page mask, an address-space ID, a wider memory-map ID, a global flag, an invalidated flag, and a physical frame field with valid and dirty bits for each half of the page pair. The staging registers are the index, the high word, the two low words, the page mask and the memory-map ID. Software writes them through a simple configuration port. It then starts one of four operations: write at index, read at index, probe, or invalidate the current space.

A mode input decides what tags an entry. When it is low, the tag is the ASID field of the high word, cut to 8 bits, or to 10 bits when the extended-ASID input is high. When it is high, the ASID mask becomes zero and the separate memory-map ID register is the tag instead. Probe, read and invalidate all follow this choice. Each operation takes one clock and reports completion with a one-cycle done pulse.

Top module: `tlb_tagged`

## Requirements
- R1: Reset clears every staging register and `done`. It also marks every entry invalidated, so a probe right after reset finds nothing.
- R2: The ASID mask is 0 when `mode_mmid` is 1. Otherwise it is 0x3FF when `ext_asid` is 1 and 0xFF when it is 0. A write stores the ASID field (high word bits 9:0) ANDed with this mask.
- R3: A write stores the high word's VPN2 (bits 31:13) and invalidated flag (bit 10), the page-mask bits 28:13, the memory-map ID, and bits 31:1 of each low word (bit 1 valid, bit 2 dirty). The global bit is stored as the AND of bit 0 of the two low words. A read returns each low word with bit 0 equal to that stored global bit.
- R4: A probe (`op_code` 2) looks for entries that are global or tag-equal, whose VPN2 is equal outside the entry's mask bits, and that are not invalidated. It writes the lowest such position into the index register, with bit 31 clear.
- R5: A probe that finds no match sets index bit 31 and leaves index bits 30:0 unchanged.
- R6: Write (`op_code` 0) and read (`op_code` 1) address the entry at (index bits 30:0) modulo the entry count. Bit 31 is ignored.
- R7: Invalidate (`op_code` 3) sets the invalidated flag on every non-global entry whose tag equals the current tag. Global entries and entries with other tags stay unchanged.
- R8: A read of a live entry loads the memory-map ID register from the entry and loads the page mask. It loads the high word with the VPN2 alone when `mode_mmid` is 1, and with the VPN2 ORed with the stored ASID when it is 0.
- R9: A read of an invalidated entry sets the high word to only bit 10 and clears both low words and the page mask.
- R10: `done` is high exactly in the cycle after each cycle with `op_valid` high, and low otherwise.
- R11: A configuration write (`cfg_addr` 0 index, 1 high, 2 low0, 3 low1, 4 mask, 5 memory-map ID) is ignored in a cycle where `op_valid` is high.
- R12: In memory-map mode, the current tag is the memory-map ID register and each entry's tag is its stored memory-map ID, so the ASID field has no effect on a probe. In ASID mode, the masked ASIDs are compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_mmid | input | 1 | 1: memory-map ID tags entries |
| ext_asid | input | 1 | 1: 10-bit ASID, 0: 8-bit ASID |
| cfg_we | input | 1 | Staging register write strobe |
| cfg_addr | input | 3 | Staging register select |
| cfg_wdata | input | 32 | Staging register write data |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 2 | 0 write, 1 read, 2 probe, 3 invalidate space |
| done | output | 1 | Operation complete pulse |
| index_o | output | 32 | Index register |
| entryhi_o | output | 32 | High word register |
| entrylo0_o | output | 32 | Low word register, even half |
| entrylo1_o | output | 32 | Low word register, odd half |
| pagemask_o | output | 32 | Page mask register |
| mmid_o | output | 16 | Memory-map ID register |

## Verification
Every operation is registered once, so `done` and all staging-register results are due on the first rising edge after the cycle in which `op_valid` is sampled high. Nothing changes before that edge or after it. The driver pushes the expected register values for an operation into a queue and raises the strobe for one cycle. The monitor samples at the following falling edge, where `done` must be high, and pops and compares every queued value there. One more falling edge later, `done` must be low again. Invalidation is observed through later probes and reads, never inside the cycle of the operation itself.

// File: rtl/tlb_tagged_pkg.sv
package tlb_tagged_pkg;
    localparam int MMID_W    = 16;
    localparam int VPN2_W    = 19;
    localparam int MASK_W    = 16;
    localparam int ASID_W    = 10;
    localparam int PFN_W     = 29;
    localparam int VPN2_LSB  = 13;
    localparam int EHINV_BIT = 10;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_PROBE = 2'd2,
        OP_INVAL = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        REG_INDEX = 3'd0,
        REG_HI    = 3'd1,
        REG_LO0   = 3'd2,
        REG_LO1   = 3'd3,
        REG_MASK  = 3'd4,
        REG_MMID  = 3'd5
    } reg_e;

    typedef struct packed {
        logic [VPN2_W-1:0] vpn2;
        logic [MASK_W-1:0] mask;
        logic [ASID_W-1:0] asid;
        logic [MMID_W-1:0] mmid;
        logic              g;
        logic              ehinv;
        logic [PFN_W-1:0]  lo0_hi;   // low word 0 bits 31:3
        logic [PFN_W-1:0]  lo1_hi;   // low word 1 bits 31:3
        logic              v0;
        logic              d0;
        logic              v1;
        logic              d1;
    } entry_t;

    typedef struct packed {
        logic [31:0]       index;
        logic [31:0]       entryhi;
        logic [31:0]       lo0;
        logic [31:0]       lo1;
        logic [31:0]       pagemask;
        logic [MMID_W-1:0] mmid;
        logic              done;
    } regs_t;
endpackage

// File: rtl/tlb_tag_sel.sv
module tlb_tag_sel
    import tlb_tagged_pkg::*;
(
    input  logic              mode_mmid,
    input  logic              ext_asid,
    input  logic [ASID_W-1:0] asid_field,
    input  logic [MMID_W-1:0] mmid_reg,
    output logic [ASID_W-1:0] asid_masked,
    output logic [MMID_W-1:0] cur_tag
);
    logic [ASID_W-1:0] asid_mask;

    always_comb begin
        if (mode_mmid)     asid_mask = '0;
        else if (ext_asid) asid_mask = 10'h3FF;
        else               asid_mask = 10'h0FF;
        asid_masked = asid_field & asid_mask;
        cur_tag     = mode_mmid ? mmid_reg
                                : {{(MMID_W-ASID_W){1'b0}}, asid_masked};
    end
endmodule

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp
    import tlb_tagged_pkg::*;
#(
    parameter int N_ENTRIES = 16
) (
    input  logic              mode_mmid,
    input  logic [MMID_W-1:0] cur_tag,
    input  logic [VPN2_W-1:0] key_vpn2,
    input  logic [VPN2_W-1:0] e_vpn2  [N_ENTRIES],
    input  logic [MASK_W-1:0] e_mask  [N_ENTRIES],
    input  logic [ASID_W-1:0] e_asid  [N_ENTRIES],
    input  logic [MMID_W-1:0] e_mmid  [N_ENTRIES],
    input  logic [N_ENTRIES-1:0] e_g,
    input  logic [N_ENTRIES-1:0] e_ehinv,
    output logic [N_ENTRIES-1:0] probe_hit,
    output logic [N_ENTRIES-1:0] space_hit
);
    localparam int PAD_W = VPN2_W - MASK_W;

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
        logic [MMID_W-1:0] ent_tag;
        logic              tag_eq;
        logic              vpn_eq;
        always_comb begin
            ent_tag = mode_mmid ? e_mmid[i]
                                : {{(MMID_W-ASID_W){1'b0}}, e_asid[i]};
            tag_eq  = (ent_tag == cur_tag);
            vpn_eq  = ((e_vpn2[i] ^ key_vpn2) & ~{{PAD_W{1'b0}}, e_mask[i]}) == '0;
            probe_hit[i] = (e_g[i] | tag_eq) & vpn_eq & ~e_ehinv[i];
            space_hit[i] = ~e_g[i] & tag_eq;
        end
    end
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic [N_ENTRIES-1:0] hits,
    output logic                 found,
    output logic [IDX_W-1:0]     pos
);
    always_comb begin
        found = |hits;
        pos   = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (hits[i]) pos = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_tagged.sv
module tlb_tagged
    import tlb_tagged_pkg::*;
#(
    parameter int N_ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_mmid,
    input  logic              ext_asid,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    output logic              done,
    output logic [31:0]       index_o,
    output logic [31:0]       entryhi_o,
    output logic [31:0]       entrylo0_o,
    output logic [31:0]       entrylo1_o,
    output logic [31:0]       pagemask_o,
    output logic [MMID_W-1:0] mmid_o
);
    localparam int IDX_W = $clog2(N_ENTRIES);

    regs_t  regs_q, regs_d;
    entry_t ent_q [N_ENTRIES];
    entry_t ent_d [N_ENTRIES];

    logic [ASID_W-1:0]    asid_masked;
    logic [MMID_W-1:0]    cur_tag;
    logic [VPN2_W-1:0]    e_vpn2 [N_ENTRIES];
    logic [MASK_W-1:0]    e_mask [N_ENTRIES];
    logic [ASID_W-1:0]    e_asid [N_ENTRIES];
    logic [MMID_W-1:0]    e_mmid [N_ENTRIES];
    logic [N_ENTRIES-1:0] e_g, e_ehinv, probe_hit, space_hit;
    logic                 found;
    logic [IDX_W-1:0]     hit_pos;
    logic [IDX_W-1:0]     sel_idx;
    op_e                  op;

    tlb_tag_sel u_tag (
        .mode_mmid   (mode_mmid),
        .ext_asid    (ext_asid),
        .asid_field  (regs_q.entryhi[ASID_W-1:0]),
        .mmid_reg    (regs_q.mmid),
        .asid_masked (asid_masked),
        .cur_tag     (cur_tag)
    );

    always_comb begin
        for (int i = 0; i < N_ENTRIES; i++) begin
            e_vpn2[i]  = ent_q[i].vpn2;
            e_mask[i]  = ent_q[i].mask;
            e_asid[i]  = ent_q[i].asid;
            e_mmid[i]  = ent_q[i].mmid;
            e_g[i]     = ent_q[i].g;
            e_ehinv[i] = ent_q[i].ehinv;
        end
    end

    tlb_entry_cmp #(.N_ENTRIES(N_ENTRIES)) u_cmp (
        .mode_mmid (mode_mmid),
        .cur_tag   (cur_tag),
        .key_vpn2  (regs_q.entryhi[31:VPN2_LSB]),
        .e_vpn2    (e_vpn2),
        .e_mask    (e_mask),
        .e_asid    (e_asid),
        .e_mmid    (e_mmid),
        .e_g       (e_g),
        .e_ehinv   (e_ehinv),
        .probe_hit (probe_hit),
        .space_hit (space_hit)
    );

    tlb_first_hit #(.N_ENTRIES(N_ENTRIES)) u_first (
        .hits  (probe_hit),
        .found (found),
        .pos   (hit_pos)
    );

    assign sel_idx = IDX_W'(regs_q.index[30:0] % 31'(N_ENTRIES));
    assign op      = op_e'(op_code);

    always_comb begin
        entry_t e;
        regs_d      = regs_q;
        ent_d       = ent_q;
        regs_d.done = op_valid;
        e           = ent_q[sel_idx];
        if (op_valid) begin
            unique case (op)
                OP_WRITE: begin
                    e.vpn2   = regs_q.entryhi[31:VPN2_LSB];
                    e.ehinv  = regs_q.entryhi[EHINV_BIT];
                    e.asid   = asid_masked;
                    e.mmid   = regs_q.mmid;
                    e.mask   = regs_q.pagemask[VPN2_LSB+MASK_W-1:VPN2_LSB];
                    e.g      = regs_q.lo0[0] & regs_q.lo1[0];
                    e.v0     = regs_q.lo0[1];
                    e.d0     = regs_q.lo0[2];
                    e.lo0_hi = regs_q.lo0[31:3];
                    e.v1     = regs_q.lo1[1];
                    e.d1     = regs_q.lo1[2];
                    e.lo1_hi = regs_q.lo1[31:3];
                    ent_d[sel_idx] = e;
                end
                OP_READ: begin
                    if (e.ehinv) begin
                        regs_d.entryhi  = 32'(1) << EHINV_BIT;
                        regs_d.lo0      = '0;
                        regs_d.lo1      = '0;
                        regs_d.pagemask = '0;
                    end else begin
                        regs_d.entryhi  = {e.vpn2, 3'b000,
                                           mode_mmid ? {ASID_W{1'b0}} : e.asid};
                        regs_d.mmid     = e.mmid;
                        regs_d.pagemask = {3'b000, e.mask, 13'b0};
                        regs_d.lo0      = {e.lo0_hi, e.d0, e.v0, e.g};
                        regs_d.lo1      = {e.lo1_hi, e.d1, e.v1, e.g};
                    end
                end
                OP_PROBE: begin
                    if (found) regs_d.index = {{(32-IDX_W){1'b0}}, hit_pos};
                    else       regs_d.index[31] = 1'b1;
                end
                OP_INVAL: begin
                    for (int i = 0; i < N_ENTRIES; i++) begin
                        if (space_hit[i]) ent_d[i].ehinv = 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (cfg_we) begin
            case (reg_e'(cfg_addr))
                REG_INDEX: regs_d.index    = cfg_wdata;
                REG_HI:    regs_d.entryhi  = cfg_wdata;
                REG_LO0:   regs_d.lo0      = cfg_wdata;
                REG_LO1:   regs_d.lo1      = cfg_wdata;
                REG_MASK:  regs_d.pagemask = cfg_wdata;
                REG_MMID:  regs_d.mmid     = cfg_wdata[MMID_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
            for (int i = 0; i < N_ENTRIES; i++) begin
                ent_q[i]       <= '0;
                ent_q[i].ehinv <= 1'b1;
            end
        end else begin
            regs_q <= regs_d;
            ent_q  <= ent_d;
        end
    end

    assign done       = regs_q.done;
    assign index_o    = regs_q.index;
    assign entryhi_o  = regs_q.entryhi;
    assign entrylo0_o = regs_q.lo0;
    assign entrylo1_o = regs_q.lo1;
    assign pagemask_o = regs_q.pagemask;
    assign mmid_o     = regs_q.mmid;
endmodule

// File: rtl/tlb_tagged_chk.sv
module tlb_tagged_chk
    import tlb_tagged_pkg::*;
#(
    parameter int N_ENTRIES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_mmid,
    input logic              cfg_we,
    input logic              op_valid,
    input logic [1:0]        op_code,
    input logic              done,
    input logic [31:0]       index_o,
    input logic [31:0]       entryhi_o,
    input logic [31:0]       entrylo0_o,
    input logic [31:0]       entrylo1_o,
    input logic [31:0]       pagemask_o,
    input logic [MMID_W-1:0] mmid_o
);
    // R10
    done_after_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> done);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !done);

    // R5
    probe_miss_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 2'd2) |=>
            (!index_o[31] || index_o[30:0] == $past(index_o[30:0])));

    // R4
    probe_hit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 2'd2) |=>
            (index_o[31] || index_o[30:0] < 31'(N_ENTRIES)));

    // R8
    mmid_read_noasid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 2'd1 && mode_mmid) |=> entryhi_o[9:0] == '0);

    // R11
    cfg_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 2'd3 && cfg_we) |=>
            ($stable(index_o) && $stable(entryhi_o) && $stable(entrylo0_o) &&
             $stable(entrylo1_o) && $stable(pagemask_o) && $stable(mmid_o)));
endmodule

bind tlb_tagged tlb_tagged_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_mmid  (mode_mmid),
    .cfg_we     (cfg_we),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .done       (done),
    .index_o    (index_o),
    .entryhi_o  (entryhi_o),
    .entrylo0_o (entrylo0_o),
    .entrylo1_o (entrylo1_o),
    .pagemask_o (pagemask_o),
    .mmid_o     (mmid_o)
);

// File: tb/tb_tlb_tagged.sv
`timescale 1ns/1ps
module tb_tlb_tagged;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_mmid = 1'b0, ext_asid = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = '0;
    logic        done;
    logic [31:0] index_o, entryhi_o, entrylo0_o, entrylo1_o, pagemask_o;
    logic [15:0] mmid_o;

    int n_chk = 0, n_fail = 0;

    typedef struct {
        string       req;
        int          sel;
        logic [31:0] val;
    } exp_t;
    exp_t sb[$];

    localparam int S_IDX = 0, S_HI = 1, S_LO0 = 2, S_LO1 = 3, S_PM = 4, S_MM = 5;

    always #2 clk = ~clk;

    tlb_tagged dut (
        .clk(clk), .rst_n(rst_n), .mode_mmid(mode_mmid), .ext_asid(ext_asid),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .op_valid(op_valid), .op_code(op_code), .done(done),
        .index_o(index_o), .entryhi_o(entryhi_o), .entrylo0_o(entrylo0_o),
        .entrylo1_o(entrylo1_o), .pagemask_o(pagemask_o), .mmid_o(mmid_o)
    );

    function automatic logic [31:0] eh(logic [18:0] vpn2, logic [9:0] asid);
        return {vpn2, 3'b000, asid};
    endfunction

    function automatic logic [31:0] peek(int sel);
        case (sel)
            S_IDX:   return index_o;
            S_HI:    return entryhi_o;
            S_LO0:   return entrylo0_o;
            S_LO1:   return entrylo1_o;
            S_PM:    return pagemask_o;
            default: return {16'b0, mmid_o};
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] want);
        n_chk++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, want);
        end
    endtask

    task automatic expect_val(string req, int sel, logic [31:0] v);
        exp_t e;
        e.req = req; e.sel = sel; e.val = v;
        sb.push_back(e);
    endtask

    // monitor: results are due on the falling edge where done is high
    always @(negedge clk) begin
        if (rst_n && done) begin
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(e.req, peek(e.sel), e.val);
            end
        end
    end

    task automatic cfg(int a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_op(int code, logic with_cfg = 1'b0);
        @(negedge clk);
        op_valid = 1'b1; op_code = 2'(code);
        if (with_cfg) begin
            cfg_we = 1'b1; cfg_addr = 3'd1; cfg_wdata = 32'hFFFF_FFFF;
        end
        @(negedge clk);
        op_valid = 1'b0; cfg_we = 1'b0;
        chk("R10 done high", {31'b0, done}, 32'd1);
        @(negedge clk);
        chk("R10 done low", {31'b0, done}, 32'd0);
    endtask

    task automatic wr_entry(int idx, logic [31:0] hi, logic [31:0] l0,
                            logic [31:0] l1, logic [31:0] pm);
        cfg(0, idx); cfg(1, hi); cfg(2, l0); cfg(3, l1); cfg(4, pm);
        do_op(0);
    endtask

    initial begin
        #(4 * 20000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 index", index_o, 32'h0);
        chk("R1 entryhi", entryhi_o, 32'h0);
        chk("R1 done", {31'b0, done}, 32'h0);
        chk("R1 mmid", {16'b0, mmid_o}, 32'h0);
        expect_val("R1 R5 probe after reset", S_IDX, 32'h8000_0000);
        do_op(2);

        // R2 R3 R6 R8: write entry 3, read back through an index that wraps
        cfg(5, 32'h55);
        wr_entry(3, eh(19'h100, 10'h2A5), 32'h43, 32'h81, 32'h0);
        cfg(1, 32'h0); cfg(5, 32'h0); cfg(0, 32'h8000_0013);
        expect_val("R2 R6 entryhi", S_HI, 32'h0020_00A5);
        expect_val("R3 lo0", S_LO0, 32'h43);
        expect_val("R3 lo1", S_LO1, 32'h81);
        expect_val("R8 mmid loaded", S_MM, 32'h55);
        expect_val("R6 index kept", S_IDX, 32'h8000_0013);
        do_op(1);

        // R3 global is AND of bit 0
        wr_entry(4, eh(19'h180, 10'h10), 32'h07, 32'h04, 32'h0);
        expect_val("R3 g and lo0", S_LO0, 32'h06);
        expect_val("R3 g and lo1", S_LO1, 32'h04);
        do_op(1);

        // R4 R5 probes
        wr_entry(5,  eh(19'h200, 10'h11), 32'h02, 32'h02, 32'h0);
        wr_entry(9,  eh(19'h200, 10'h11), 32'h02, 32'h02, 32'h0);
        wr_entry(7,  eh(19'h300, 10'h33), 32'h01, 32'h01, 32'h0);
        wr_entry(11, eh(19'h400, 10'h11), 32'h02, 32'h02, 32'h0000_2000);
        cfg(1, eh(19'h200, 10'h11));
        expect_val("R4 lowest match", S_IDX, 32'd5);
        do_op(2);
        cfg(1, eh(19'h200, 10'h12));
        expect_val("R5 miss keeps low bits", S_IDX, 32'h8000_0005);
        do_op(2);
        cfg(1, eh(19'h300, 10'h44));
        expect_val("R4 global match", S_IDX, 32'd7);
        do_op(2);
        cfg(1, eh(19'h401, 10'h11));
        expect_val("R4 masked vpn match", S_IDX, 32'd11);
        do_op(2);
        cfg(1, eh(19'h402, 10'h11));
        expect_val("R5 vpn miss", S_IDX, 32'h8000_000B);
        do_op(2);

        // R7 invalidate space 0x11
        cfg(1, eh(19'h0, 10'h11));
        do_op(3);
        cfg(0, 32'd2); cfg(1, eh(19'h200, 10'h11));
        expect_val("R7 tagged entries gone", S_IDX, 32'h8000_0002);
        do_op(2);
        cfg(1, eh(19'h300, 10'h11));
        expect_val("R7 global kept", S_IDX, 32'd7);
        do_op(2);
        cfg(1, eh(19'h100, 10'hA5));
        expect_val("R7 other space kept", S_IDX, 32'd3);
        do_op(2);
        // R9 read of invalidated entry
        cfg(0, 32'd5); cfg(2, 32'h43); cfg(3, 32'h81); cfg(4, 32'h2000);
        expect_val("R9 entryhi", S_HI, 32'h0000_0400);
        expect_val("R9 lo0", S_LO0, 32'h0);
        expect_val("R9 lo1", S_LO1, 32'h0);
        expect_val("R9 pagemask", S_PM, 32'h0);
        do_op(1);

        // R2 extended ASID
        ext_asid = 1'b1;
        wr_entry(14, eh(19'h600, 10'h2A5), 32'h02, 32'h02, 32'h0);
        expect_val("R2 ext asid", S_HI, 32'h00C0_02A5);
        do_op(1);

        // R8 R12 memory-map mode
        mode_mmid = 1'b1;
        cfg(5, 32'hBEEF);
        wr_entry(12, eh(19'h500, 10'h77), 32'h02, 32'h02, 32'h0);
        cfg(5, 32'h1234);
        expect_val("R8 vpn only", S_HI, 32'h00A0_0000);
        expect_val("R8 mmid from entry", S_MM, 32'hBEEF);
        do_op(1);
        cfg(1, eh(19'h500, 10'h99));
        expect_val("R12 mmid match", S_IDX, 32'd12);
        do_op(2);
        cfg(5, 32'h1111);
        expect_val("R12 mmid differs", S_IDX, 32'h8000_000C);
        do_op(2);
        mode_mmid = 1'b0;
        cfg(1, eh(19'h500, 10'h0));
        expect_val("R2 asid stored as zero", S_IDX, 32'd12);
        do_op(2);

        // R11 config write in an op cycle
        expect_val("R11 entryhi unchanged", S_HI, 32'h00A0_0000);
        expect_val("R11 probe result", S_IDX, 32'd12);
        do_op(2, 1'b1);

        repeat (2) @(negedge clk);
        chk("scoreboard drained", 32'(sb.size()), 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule